// File: doc/BRIEF.md
# Multiplexed Address/Data Burst Slave

This block is a slave on a synchronous bus where one set of lines carries an address in one slot and data words in the slots that follow. The master opens a transfer with an address slot, marked by the address-valid line. In that slot it also gives the direction (high for read, low for write, seen from the master). If the top address bit selects this module, the slave takes the lower address bits as the start of a fixed four-word burst. It then serves one word for each data slot, and it advances the word address itself, so the master sends no further address.

Data slots are qualified by an active-low valid strobe that the master drives. While the strobe is high the burst pauses in place. On a write burst each qualified slot stores the bus word into a 128-word internal store. On a read burst the slave puts the current word on its output lines and raises its output enable in that same slot. The incoming and outgoing halves of the shared lines are separate ports, and pad control is left to the surrounding chip.

Top module: `ab_mux_burst_slave`

## Requirements
- R1: While reset is high and in the first cycle after it, bus_oe is 0 and no burst is open.
- R2: A cycle with ale=1 is an address slot. If bus_in[7]=0, it opens a four-word burst that starts at word bus_in[6:0] and has the direction rw gives in that slot (1 read, 0 write). rw in later data slots has no effect. If bus_in[7]=1, any open burst is closed, and the following data slots neither store words nor raise bus_oe.
- R3: In a write burst, the four data slots (ale=0, dav_n=0) store bus_in at start, start+1, start+2 and start+3.
- R4: In a read burst, bus_out carries the stored word at the current burst address during each data slot, in that same cycle.
- R5: bus_oe is 1 only in data slots of an open read burst addressed to this module, and is 0 in address slots, in idle cycles and in write bursts.
- R6: Burst addresses wrap within the 128-word space. A burst starting at 0x7E uses words 0x7E, 0x7F, 0x00 and 0x01.
- R7: A cycle with ale=0 and dav_n=1 inside a burst neither stores a word, nor advances the address, nor raises bus_oe. The burst resumes at the same word at the next data slot.
- R8: After the fourth data slot the burst is closed. Further data slots store nothing and leave bus_oe at 0.
- R9: ale=1 wins over dav_n=0 in the same cycle. The cycle is treated only as an address slot: nothing is stored, bus_oe is 0, and any open burst is abandoned for the new one.
- R10: Stored words persist across bursts until a later write burst overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | 8 | Shared lines as seen by the slave: address in address slots, write data in data slots |
| ale | input | 1 | Address-valid: high marks an address slot |
| rw | input | 1 | Direction, sampled in the address slot: 1 read, 0 write |
| dav_n | input | 1 | Active-low data-valid strobe from the master |
| bus_out | output | 8 | Read word driven toward the shared lines |
| bus_oe | output | 1 | Output enable for bus_out |

## Verification
Two functions can meet in one cycle: a new address slot and a data slot of a burst that is still open, because the master may raise ale while holding dav_n low. The bench provokes this in the middle of a read burst and in the middle of a write burst. It checks that bus_oe stays low in that cycle, that the address value on the lines is not stored as data in the abandoned write burst, and that the next four read words come from the new start address. A stall cycle just before a burst ends and an extra data slot after the last beat are judged the same way: at the port, through bus_oe and later read-back.

// File: rtl/ab_pkg.sv
package ab_pkg;

    parameter int ADDR_W    = 8;
    parameter int DATA_W    = 8;
    parameter int BURST_LEN = 4;

    localparam int OFS_W = ADDR_W - 1;
    localparam int DEPTH = 1 << OFS_W;
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    typedef enum logic [1:0] {
        BST_IDLE,
        BST_WRITE,
        BST_READ
    } burst_st_e;

    typedef enum logic [1:0] {
        SK_NONE,
        SK_ADDR_HIT,
        SK_ADDR_MISS,
        SK_DATA
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e          kind;
        logic                rd;
        logic [OFS_W-1:0]    ofs;
        logic [DATA_W-1:0]   word;
    } slot_t;

    function automatic logic [OFS_W-1:0] ofs_next(input logic [OFS_W-1:0] cur);
        return cur + OFS_W'(1);
    endfunction

    function automatic logic addr_is_mine(input logic [ADDR_W-1:0] a, input logic sel);
        return a[ADDR_W-1] == sel;
    endfunction

endpackage

// File: rtl/ab_slot_decode.sv
module ab_slot_decode
    import ab_pkg::*;
#(
    parameter logic MOD_SEL = 1'b0
) (
    input  logic [ADDR_W-1:0] bus_in,
    input  logic              ale,
    input  logic              rw,
    input  logic              dav_n,
    output slot_t             slot
);

    always_comb begin
        slot.rd   = rw;
        slot.ofs  = bus_in[OFS_W-1:0];
        slot.word = bus_in[DATA_W-1:0];
        if (ale) begin
            slot.kind = addr_is_mine(bus_in, MOD_SEL) ? SK_ADDR_HIT : SK_ADDR_MISS;
        end else if (!dav_n) begin
            slot.kind = SK_DATA;
        end else begin
            slot.kind = SK_NONE;
        end
    end

endmodule

// File: rtl/ab_burst_seq.sv
module ab_burst_seq
    import ab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  slot_t            slot,
    output logic [OFS_W-1:0] cur_ofs,
    output logic             wr_en,
    output logic             rd_drive
);

    burst_st_e         st_q;
    logic [CNT_W-1:0]  left_q;
    logic [OFS_W-1:0]  ofs_q;
    logic              beat;

    assign beat     = (slot.kind == SK_DATA) && (st_q != BST_IDLE);
    assign wr_en    = beat && (st_q == BST_WRITE);
    assign rd_drive = beat && (st_q == BST_READ);
    assign cur_ofs  = ofs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= BST_IDLE;
            left_q <= '0;
            ofs_q  <= '0;
        end else begin
            case (slot.kind)
                SK_ADDR_HIT: begin
                    st_q   <= slot.rd ? BST_READ : BST_WRITE;
                    left_q <= CNT_W'(BURST_LEN);
                    ofs_q  <= slot.ofs;
                end
                SK_ADDR_MISS: begin
                    st_q   <= BST_IDLE;
                    left_q <= '0;
                end
                SK_DATA: begin
                    if (st_q != BST_IDLE) begin
                        ofs_q  <= ofs_next(ofs_q);
                        left_q <= left_q - CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            st_q <= BST_IDLE;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    AST_HIT_LOADS: assert property (@(posedge clk) disable iff (rst)
        slot.kind == SK_ADDR_HIT |=> (ofs_q == $past(slot.ofs)) && (left_q == CNT_W'(BURST_LEN))) // R2
        else $error("hit did not load start");

    AST_MISS_CLOSES: assert property (@(posedge clk) disable iff (rst)
        slot.kind == SK_ADDR_MISS |=> st_q == BST_IDLE) // R2
        else $error("miss left burst open");

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        slot.kind == SK_NONE |=> $stable(ofs_q) && $stable(left_q) && $stable(st_q)) // R7
        else $error("stall moved burst");

    AST_BEAT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        beat |=> ofs_q == OFS_W'($past(ofs_q) + 1)) // R6
        else $error("beat did not advance");

    AST_LAST_BEAT_ENDS: assert property (@(posedge clk) disable iff (rst)
        beat && left_q == CNT_W'(1) |=> st_q == BST_IDLE) // R8
        else $error("burst ran past its length");

endmodule

// File: rtl/ab_word_store.sv
module ab_word_store
    import ab_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[ofs] <= wdata;
        end
    end

    assign rdata = mem[ofs];

    AST_WRITE_LANDS: assert property (@(posedge clk)
        wr_en |=> mem[$past(ofs)] == $past(wdata)) // R3
        else $error("word not stored");

endmodule

// File: rtl/ab_mux_burst_slave.sv
module ab_mux_burst_slave
    import ab_pkg::*;
#(
    parameter logic MOD_SEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_in,
    input  logic              ale,
    input  logic              rw,
    input  logic              dav_n,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);

    slot_t             slot;
    logic [OFS_W-1:0]  cur_ofs;
    logic              wr_en;
    logic              rd_drive;
    logic [DATA_W-1:0] rdata;

    ab_slot_decode #(.MOD_SEL(MOD_SEL)) u_dec (
        .bus_in (bus_in),
        .ale    (ale),
        .rw     (rw),
        .dav_n  (dav_n),
        .slot   (slot)
    );

    ab_burst_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .slot     (slot),
        .cur_ofs  (cur_ofs),
        .wr_en    (wr_en),
        .rd_drive (rd_drive)
    );

    ab_word_store u_store (
        .clk   (clk),
        .wr_en (wr_en),
        .ofs   (cur_ofs),
        .wdata (slot.word),
        .rdata (rdata)
    );

    assign bus_oe  = rd_drive;
    assign bus_out = rd_drive ? rdata : '0;

    AST_OE_DATA_SLOT: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> !ale && !dav_n) // R5
        else $error("oe outside data slot");

    AST_ADDR_WINS: assert property (@(posedge clk) disable iff (rst)
        ale |-> !bus_oe && !wr_en) // R9
        else $error("address slot treated as data");

    AST_NO_OE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !bus_oe) // R1
        else $error("oe right after reset");

endmodule

// File: tb/ab_mux_burst_slave_bench.sv
module ab_mux_burst_slave_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_in;
    logic       ale, rw, dav_n;
    logic [7:0] bus_out;
    logic       bus_oe;

    always #5 clk = ~clk;

    ab_mux_burst_slave u_ab_mux_burst_slave (
        .clk(clk), .rst(rst), .bus_in(bus_in), .ale(ale), .rw(rw),
        .dav_n(dav_n), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    int         n_chk = 0;
    int         n_bad = 0;
    bit         live = 0;
    bit         done = 0;
    logic       exp_oe = 1'b0;
    string      cur_req = "R1";
    logic [7:0] ref_mem [128];
    logic [7:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (live) begin
            chk(bus_oe == exp_oe, cur_req, "bus_oe", bus_oe, exp_oe);
            if (bus_oe) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected read word", bus_out, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(bus_out == e, cur_req, "read word", bus_out, e);
                end
            end
        end
    end

    task automatic drive(input logic a, input logic r, input logic dn, input logic [7:0] b,
                         input logic eoe, input logic [7:0] ew, input string req);
        @(posedge clk);
        #1;
        ale = a; rw = r; dav_n = dn; bus_in = b;
        exp_oe = eoe; cur_req = req;
        if (eoe) exp_q.push_back(ew);
    endtask

    task automatic idle(input string req);
        drive(1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, req);
    endtask

    task automatic wburst(input logic [7:0] a, input logic [7:0] base, input string req);
        drive(1'b1, 1'b0, 1'b1, a, 1'b0, 8'h00, req);
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 1'b1, 1'b0, base + 8'(i), 1'b0, 8'h00, req);
            if (!a[7]) ref_mem[7'(a[6:0] + 7'(i))] = base + 8'(i);
        end
    endtask

    task automatic rburst(input logic [7:0] a, input string req);
        drive(1'b1, 1'b1, 1'b1, a, 1'b0, 8'h00, req);
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 1'b0, 1'b0, 8'h00, !a[7], ref_mem[7'(a[6:0] + 7'(i))], req);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog run hung actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ale = 1'b0; rw = 1'b0; dav_n = 1'b1; bus_in = 8'h00;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(bus_oe == 1'b0, "R1", "bus_oe in reset", bus_oe, 0);
        @(posedge clk); #1;
        rst = 1'b0; live = 1;
        idle("R1");

        // R3 write then R4 read (rw low in read data slots: R2)
        wburst(8'h10, 8'hA0, "R3");
        rburst(8'h10, "R4");

        // R6 wrap
        wburst(8'h7E, 8'h30, "R6");
        rburst(8'h7E, "R6");

        // R2 foreign module: no store, no drive
        wburst(8'h90, 8'h55, "R2");
        rburst(8'h90, "R2");
        rburst(8'h10, "R10");

        // R7 stalls in write and read bursts
        drive(1'b1, 1'b0, 1'b1, 8'h40, 1'b0, 8'h00, "R7");
        drive(1'b0, 1'b0, 1'b0, 8'hD0, 1'b0, 8'h00, "R7"); ref_mem[7'h40] = 8'hD0;
        idle("R7"); idle("R7");
        drive(1'b0, 1'b0, 1'b0, 8'hD1, 1'b0, 8'h00, "R7"); ref_mem[7'h41] = 8'hD1;
        idle("R7");
        drive(1'b0, 1'b0, 1'b0, 8'hD2, 1'b0, 8'h00, "R7"); ref_mem[7'h42] = 8'hD2;
        drive(1'b0, 1'b0, 1'b0, 8'hD3, 1'b0, 8'h00, "R7"); ref_mem[7'h43] = 8'hD3;
        drive(1'b1, 1'b1, 1'b1, 8'h40, 1'b0, 8'h00, "R7");
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hD0, "R7");
        idle("R7");
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hD1, "R7");
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hD2, "R7");
        idle("R7"); idle("R7");
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'hD3, "R7");

        // R8 burst end
        wburst(8'h54, 8'h11, "R8");
        wburst(8'h50, 8'h60, "R8");
        drive(1'b0, 1'b0, 1'b0, 8'hEE, 1'b0, 8'h00, "R8");
        rburst(8'h54, "R8");
        drive(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R8");
        idle("R8");

        // R9 new address slot over an open read burst
        drive(1'b1, 1'b1, 1'b1, 8'h10, 1'b0, 8'h00, "R9");
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, ref_mem[7'h10], "R9");
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, ref_mem[7'h11], "R9");
        drive(1'b1, 1'b1, 1'b0, 8'h7E, 1'b0, 8'h00, "R9");
        for (int i = 0; i < 4; i++)
            drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, ref_mem[7'(7'h7E + 7'(i))], "R9");

        // R9 new address slot over an open write burst
        wburst(8'h20, 8'hC0, "R9");
        drive(1'b1, 1'b0, 1'b1, 8'h20, 1'b0, 8'h00, "R9");
        drive(1'b0, 1'b0, 1'b0, 8'h99, 1'b0, 8'h00, "R9"); ref_mem[7'h20] = 8'h99;
        drive(1'b1, 1'b1, 1'b0, 8'h20, 1'b0, 8'h00, "R9");
        for (int i = 0; i < 4; i++)
            drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, ref_mem[7'(7'h20 + 7'(i))], "R9");
        idle("R9");

        // R10 earlier data still intact
        rburst(8'h7E, "R10");
        idle("R10");
        @(negedge clk);
        chk(exp_q.size() == 0, "R4", "words left unread", exp_q.size(), 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule